// File: doc/BRIEF.md
# Address-Match Breakpoint Controller

This block watches the program address that a CPU presents on opcode fetches and compares it against a break address that software loads one byte at a time. When the fetched address equals the stored address and address breaks are enabled, a breakpoint request is raised. Software can also raise the request directly by setting a force bit in the control register. The request is not taken in the middle of an instruction. It waits until the CPU reports an instruction boundary. At that boundary the block tells the CPU to load a software-interrupt opcode in place of the next instruction.

While the break routine runs, the block reports itself active and holds the watchdog. It supplies the address of the first byte of the break vector pair, and that address depends on whether the CPU is in monitor mode. A return-from-interrupt strobe from the CPU ends the active state. Breaks do not nest: while a break is active, new matches and new force requests are discarded.

Top module: `brk_ctrl`

## Requirements
- R1: A synchronous active-low reset clears both break address bytes and the enable, force and active bits, and removes any pending request, so bkpt_req and wdog_hold are 0 after it.
- R2: Register map on reg_addr. Address 0 is the high address byte and address 1 is the low byte; both are read/write. Address 2 is control: bit 7 is enable (read/write), bit 6 is active (read-only), and bit 5 is force (write one to set; writing zero has no effect). Other control bits read 0, and address 3 reads 0. Reads are combinational.
- R3: When enable is 1 and fetch_vld is 1 and pc_addr equals {high byte, low byte}, bkpt_req is 1 from the next cycle onward. A match on only one byte raises no request.
- R4: An address presented with fetch_vld at 0, or presented while enable is 0, raises no request.
- R5: A raised request stays raised until a cycle with instr_end at 1. In that cycle swi_load is 1. From the next cycle, active (control bit 6) and wdog_hold are 1 and bkpt_req is 0.
- R6: Writing 1 to the force bit while no break is active raises bkpt_req from the next cycle, even if enable is 0. The force bit reads 1 until the break is taken, and it clears itself when the break is taken.
- R7: vec_addr is 0xFFFC when monitor_mode is 0 and 0xFEFC when monitor_mode is 1.
- R8: rti_done while active clears active and wdog_hold from the next cycle. Active stays 1 until that strobe arrives.
- R9: While a break is active, address matches and force writes are ignored, so the force bit reads 0 and no second break follows. A match that persists while the request is pending produces exactly one break.
- R10: instr_end with no raised request leaves swi_load at 0 and does not set active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_addr | input | 16 | Program address of the current cycle |
| fetch_vld | input | 1 | Current cycle is an opcode fetch |
| instr_end | input | 1 | Current instruction completes in this cycle |
| rti_done | input | 1 | Return-from-interrupt executed |
| monitor_mode | input | 1 | CPU is in monitor mode |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| bkpt_req | output | 1 | Breakpoint request waiting for an instruction boundary |
| swi_load | output | 1 | Load a software-interrupt opcode now |
| vec_addr | output | 16 | Address of the first byte of the break vector pair |
| wdog_hold | output | 1 | Break active; hold the watchdog |

## Verification
A pending flag that is lost or kept too long shows at the ports within one cycle. Either bkpt_req falls before any instr_end, or it remains high after swi_load. A stuck or missing active bit shows on wdog_hold and control bit 6 in the cycle after the boundary. It also shows in the cycle after rti_done. A comparator that checks the wrong byte, or that ignores fetch_vld or enable, raises or omits bkpt_req one cycle after the offending fetch. A force bit that fails to set or clear is visible directly in the control readback.

// File: rtl/brk_pkg.sv
package brk_pkg;
    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned CTL_EN_BIT  = 7;
    localparam int unsigned CTL_ACT_BIT = 6;
    localparam int unsigned CTL_FRC_BIT = 5;

    typedef struct packed {
        logic pending;
        logic active;
    } seq_state_t;
endpackage

// File: rtl/brk_cmp.sv
module brk_cmp
    import brk_pkg::*;
#(
    parameter int unsigned NBYTES = 2,
    localparam int unsigned AW = NBYTES * BYTE_W
) (
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] ref_i,
    output logic          match_o
);
    logic [NBYTES-1:0] byte_eq;

    // one comparator per stored byte
    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        assign byte_eq[g] = (addr_i[g*BYTE_W +: BYTE_W] == ref_i[g*BYTE_W +: BYTE_W]);
    end

    assign match_o = &byte_eq;
endmodule

// File: rtl/brk_regs.sv
module brk_regs
    import brk_pkg::*;
#(
    parameter int unsigned NBYTES = 2,
    localparam int unsigned AW  = NBYTES * BYTE_W,
    localparam int unsigned RAW = $clog2(NBYTES + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RAW-1:0]    reg_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              active_i,
    input  logic              take_i,
    output logic [BYTE_W-1:0] rd_data,
    output logic [AW-1:0]     brk_addr_o,
    output logic              en_o,
    output logic              frc_o
);
    typedef struct packed {
        logic [NBYTES-1:0][BYTE_W-1:0] brk;
        logic                          en;
        logic                          frc;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (take_i) begin
            regs_d.frc = 1'b0;
        end
        if (wr_en) begin
            for (int i = 0; i < NBYTES; i++) begin
                // address 0 holds the most significant byte
                if (reg_addr == RAW'(NBYTES - 1 - i)) begin
                    regs_d.brk[i] = wr_data;
                end
            end
            if (reg_addr == RAW'(NBYTES)) begin
                regs_d.en = wr_data[CTL_EN_BIT];
                if (wr_data[CTL_FRC_BIT] && !active_i) begin
                    regs_d.frc = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (reg_addr == RAW'(NBYTES - 1 - i)) begin
                rd_data = regs_q.brk[i];
            end
        end
        if (reg_addr == RAW'(NBYTES)) begin
            rd_data[CTL_EN_BIT]  = regs_q.en;
            rd_data[CTL_ACT_BIT] = active_i;
            rd_data[CTL_FRC_BIT] = regs_q.frc;
        end
    end

    assign brk_addr_o = regs_q.brk;
    assign en_o       = regs_q.en;
    assign frc_o      = regs_q.frc;
endmodule

// File: rtl/brk_seq.sv
module brk_seq
    import brk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match_i,
    input  logic en_i,
    input  logic fetch_vld,
    input  logic frc_i,
    input  logic instr_end,
    input  logic rti_done,
    output logic active_o,
    output logic req_o,
    output logic take_o
);
    seq_state_t st_d, st_q;
    logic hit;
    logic req;
    logic take;

    always_comb begin
        st_d = st_q;
        hit  = match_i && en_i && fetch_vld && !st_q.active;
        req  = (st_q.pending || frc_i) && !st_q.active;
        take = req && instr_end;
        if (hit) begin
            st_d.pending = 1'b1;
        end
        if (take) begin
            st_d.pending = 1'b0;
            st_d.active  = 1'b1;
        end
        if (st_q.active && rti_done) begin
            st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
    assign req_o    = req;
    assign take_o   = take;
endmodule

// File: rtl/brk_ctrl.sv
module brk_ctrl
    import brk_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] VEC_NORM = 'hFFFC,
    parameter logic [ADDR_W-1:0] VEC_MON  = 'hFEFC,
    localparam int unsigned NBYTES = ADDR_W / BYTE_W,
    localparam int unsigned RAW    = $clog2(NBYTES + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pc_addr,
    input  logic              fetch_vld,
    input  logic              instr_end,
    input  logic              rti_done,
    input  logic              monitor_mode,
    input  logic              reg_we,
    input  logic [RAW-1:0]    reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              bkpt_req,
    output logic              swi_load,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              wdog_hold
);
    logic [ADDR_W-1:0] brk_addr;
    logic              en;
    logic              frc;
    logic              active;
    logic              take;
    logic              match;

    brk_regs #(.NBYTES(NBYTES)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_we),
        .reg_addr   (reg_addr),
        .wr_data    (reg_wdata),
        .active_i   (active),
        .take_i     (take),
        .rd_data    (reg_rdata),
        .brk_addr_o (brk_addr),
        .en_o       (en),
        .frc_o      (frc)
    );

    brk_cmp #(.NBYTES(NBYTES)) i_cmp (
        .addr_i  (pc_addr),
        .ref_i   (brk_addr),
        .match_o (match)
    );

    brk_seq i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .match_i   (match),
        .en_i      (en),
        .fetch_vld (fetch_vld),
        .frc_i     (frc),
        .instr_end (instr_end),
        .rti_done  (rti_done),
        .active_o  (active),
        .req_o     (bkpt_req),
        .take_o    (take)
    );

    assign swi_load  = take;
    assign wdog_hold = active;
    assign vec_addr  = monitor_mode ? VEC_MON : VEC_NORM;
endmodule

// File: rtl/brk_chk.sv
module brk_chk (
    input logic clk,
    input logic rst_n,
    input logic instr_end,
    input logic rti_done,
    input logic bkpt_req,
    input logic swi_load,
    input logic wdog_hold
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!wdog_hold && !bkpt_req));

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bkpt_req && !instr_end) |=> bkpt_req);

    // R5
    swi_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swi_load |=> (wdog_hold && !bkpt_req));

    // R8
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdog_hold && !rti_done) |=> wdog_hold);

    // R8
    rti_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdog_hold && rti_done) |=> !wdog_hold);

    // R9
    no_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_hold |-> !swi_load);
endmodule

bind brk_ctrl brk_chk i_chk (.*);

// File: tb/test_brk_ctrl.sv
`timescale 1ns/1ps
module test_brk_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pc_addr = '0;
    logic        fetch_vld = 1'b0;
    logic        instr_end = 1'b0;
    logic        rti_done = 1'b0;
    logic        monitor_mode = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        bkpt_req;
    logic        swi_load;
    logic [15:0] vec_addr;
    logic        wdog_hold;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    brk_ctrl i_brk_ctrl (
        .clk(clk), .rst_n(rst_n), .pc_addr(pc_addr), .fetch_vld(fetch_vld),
        .instr_end(instr_end), .rti_done(rti_done), .monitor_mode(monitor_mode),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .bkpt_req(bkpt_req), .swi_load(swi_load),
        .vec_addr(vec_addr), .wdog_hold(wdog_hold)
    );

    // {reg_addr, write data, expected readback}
    localparam logic [17:0] TBL [8] = '{
        {2'd0, 8'h12, 8'h12},
        {2'd1, 8'h34, 8'h34},
        {2'd2, 8'hC0, 8'h80},
        {2'd2, 8'h1F, 8'h00},
        {2'd3, 8'hFF, 8'h00},
        {2'd0, 8'hAB, 8'hAB},
        {2'd2, 8'h80, 8'h80},
        {2'd0, 8'h12, 8'h12}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a);
        reg_addr = a;
        #0.1;
    endtask

    initial begin
        @(negedge clk);
        tick(); tick();
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd0); chk("R1 hi", {8'h0, reg_rdata}, 16'h0000);
        rd(2'd1); chk("R1 lo", {8'h0, reg_rdata}, 16'h0000);
        rd(2'd2); chk("R1 ctl", {8'h0, reg_rdata}, 16'h0000);
        chk("R1 req", {15'h0, bkpt_req}, 16'h0);
        chk("R1 hold", {15'h0, wdog_hold}, 16'h0);

        // R2 register map table
        for (int i = 0; i < 8; i++) begin
            wr(TBL[i][17:16], TBL[i][15:8]);
            rd(TBL[i][17:16]);
            chk("R2 readback", {8'h0, reg_rdata}, {8'h0, TBL[i][7:0]});
            chk("R2 no req", {15'h0, bkpt_req}, 16'h0);
        end

        // R7 vector selection
        monitor_mode = 1'b0; #0.1;
        chk("R7 normal", vec_addr, 16'hFFFC);
        monitor_mode = 1'b1; #0.1;
        chk("R7 monitor", vec_addr, 16'hFEFC);
        monitor_mode = 1'b0;

        // R3 partial matches
        pc_addr = 16'h1299; fetch_vld = 1'b1; tick();
        chk("R3 low byte differs", {15'h0, bkpt_req}, 16'h0);
        pc_addr = 16'h5534; tick();
        chk("R3 high byte differs", {15'h0, bkpt_req}, 16'h0);

        // R4 not a fetch
        pc_addr = 16'h1234; fetch_vld = 1'b0; tick();
        chk("R4 no fetch", {15'h0, bkpt_req}, 16'h0);

        // R10 boundary without request
        instr_end = 1'b1; #0.1;
        chk("R10 swi", {15'h0, swi_load}, 16'h0);
        tick(); instr_end = 1'b0;
        chk("R10 hold", {15'h0, wdog_hold}, 16'h0);

        // R3 full match, persistent while pending
        fetch_vld = 1'b1; tick();
        chk("R3 match req", {15'h0, bkpt_req}, 16'h1);
        tick(); tick();
        chk("R5 held", {15'h0, bkpt_req}, 16'h1);
        chk("R5 not yet", {15'h0, wdog_hold}, 16'h0);
        instr_end = 1'b1; #0.1;
        chk("R5 swi", {15'h0, swi_load}, 16'h1);
        tick(); instr_end = 1'b0;
        chk("R5 hold", {15'h0, wdog_hold}, 16'h1);
        chk("R5 req clr", {15'h0, bkpt_req}, 16'h0);
        rd(2'd2); chk("R5 ctl", {8'h0, reg_rdata}, 16'h00C0);

        // R9 match during active ignored
        tick(); tick();
        chk("R9 req while active", {15'h0, bkpt_req}, 16'h0);
        instr_end = 1'b1; #0.1;
        chk("R9 no swi", {15'h0, swi_load}, 16'h0);
        tick(); instr_end = 1'b0;
        wr(2'd2, 8'hA0);
        rd(2'd2); chk("R9 force ignored", {8'h0, reg_rdata}, 16'h00C0);
        fetch_vld = 1'b0;

        // R8 return
        tick(); chk("R8 still active", {15'h0, wdog_hold}, 16'h1);
        rti_done = 1'b1; tick(); rti_done = 1'b0;
        chk("R8 hold clr", {15'h0, wdog_hold}, 16'h0);
        rd(2'd2); chk("R8 ctl", {8'h0, reg_rdata}, 16'h0080);
        chk("R9 single break", {15'h0, bkpt_req}, 16'h0);

        // R6 force with enable clear
        wr(2'd2, 8'h20);
        chk("R6 req", {15'h0, bkpt_req}, 16'h1);
        rd(2'd2); chk("R6 ctl", {8'h0, reg_rdata}, 16'h0020);
        instr_end = 1'b1; #0.1;
        chk("R6 swi", {15'h0, swi_load}, 16'h1);
        tick(); instr_end = 1'b0;
        rd(2'd2); chk("R6 self clear", {8'h0, reg_rdata}, 16'h0040);
        rti_done = 1'b1; tick(); rti_done = 1'b0;
        rd(2'd2); chk("R8 ctl idle", {8'h0, reg_rdata}, 16'h0000);

        // R4 enable clear
        pc_addr = 16'h1234; fetch_vld = 1'b1; tick(); tick();
        chk("R4 disabled", {15'h0, bkpt_req}, 16'h0);
        fetch_vld = 1'b0;

        // R1 reset while active
        wr(2'd2, 8'h20);
        instr_end = 1'b1; tick(); instr_end = 1'b0;
        chk("R1 pre active", {15'h0, wdog_hold}, 16'h1);
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        chk("R1 hold clr", {15'h0, wdog_hold}, 16'h0);
        rd(2'd0); chk("R1 hi clr", {8'h0, reg_rdata}, 16'h0000);
        rd(2'd1); chk("R1 lo clr", {8'h0, reg_rdata}, 16'h0000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule